// File: doc/BRIEF.md
# Pipelined ADC Redundant-Digit Correction

This block turns the raw comparator decisions of a nine-stage pipelined converter into one straight offset-binary output word per sampling clock. Eight front stages each deliver a redundant three-level decision (0, 1 or 2). A last flash stage delivers a plain two-bit code. Each stage doubles the residue it hands on, so a stage's code carries twice the weight of the next stage's code. Adding the codes at those overlapping weights lets a later stage make up for a decision that an earlier comparator placed on the wrong side of its threshold. Offsets within the redundancy range therefore produce no missing codes.

A sample moves one stage further every half clock. The codes of one sample therefore reach the block spread over five clock cycles: two front stages in each cycle, then the flash code. The block delays every lane by the right number of cycles and adds the aligned codes. It registers the result and raises a valid strobe once every lane carries data taken after reset. An illegal front-stage code (3) can push the sum past full scale, and the output then pins at the top code.

Top module: `adc_digital_correct`

## Requirements
- R1: The output word is the sum over front stages k = 1..8 of code_k × 2^(9−k), plus the flash code × 1. Stage 1 weighs 256 and stage 8 weighs 2. A sample with every code equal to 1 gives 511.
- R2: Stage k's code sits on `stage_codes[2k-1:2k-2]`, so stage 1 uses bits 1:0. For a sample whose stage 1 and 2 codes are presented in cycle c, stages 2j−1 and 2j are presented in cycle c+j−1, and the flash code in cycle c+4.
- R3: The corrected word of that sample is driven from the rising edge that ends cycle c+4. Counting the edge that captures the stage 1 code, that is the fifth rising edge. Each following sample leaves one clock after the previous one.
- R4: With legal codes only (front 0..2, flash 0..3), the sum never needs clamping. All zeros give 0, and all front codes 2 with flash 3 give 1023.
- R5: When an illegal front code 3 pushes the sum above 1023, the output is 1023. An illegal code whose sum stays in range passes through unclamped (stage 1 = 3 with all other codes 0 gives 768).
- R6: `out_valid` is low after reset and rises on the fifth rising edge after `rst_n` goes high. It then stays high until the next reset.
- R7: `rst_n` is synchronous and active low. It clears the output word, the valid strobe and every deskew register. Codes presented during reset therefore add nothing to the words that follow it.
- R8: Redundant decisions that mean the same value give the same word. A code pair (1, 0) on adjacent front stages gives the same output as (0, 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_codes | input | 16 | Two-bit decision lanes of the eight front stages, stage 1 in the low bits |
| flash_code | input | 2 | Two-bit code of the final flash stage |
| out_word | output | 10 | Corrected straight offset-binary sample |
| out_valid | output | 1 | High when out_word belongs to a sample fully taken after reset |

## Verification
Each stage is set to 1 in turn while the others are held at 0. This isolates every weight and would expose a swapped or mis-shifted lane that an all-ones midscale word hides. The all-zero, all-two and flash-only words pin both ends of the range. Illegal codes are applied with sums both above and inside the range, which separates correct clamping from clamping that is always on or never on. A stream of pseudo-random legal samples that change every clock, together with garbage codes held during reset, tells correct per-lane delays apart from delays that are off by one cycle, and shows whether reset flushes the deskew registers.

// File: rtl/adc_corr_pkg.sv
// Shared types and helpers for the pipelined ADC correction block.
// Assumes two-bit decision codes; code 3 is illegal for a redundant stage.
package adc_corr_pkg;

    typedef logic [1:0] dcode_t;

    localparam dcode_t CODE_ILLEGAL = 2'd3;

    // Cycles a front-stage lane must wait so it meets the flash code.
    function automatic int lane_lag(input int stage_idx, input int lanes_per_clk,
                                    input int skew_max);
        return skew_max - (stage_idx / lanes_per_clk);
    endfunction

endpackage

// File: rtl/adc_code_deskew.sv
// Delays each front-stage lane so all codes of one sample line up with
// the flash code. Assumes lanes arrive LANES_PER_CLK per clock in stage
// order, stage 0 first; a lane whose lag works out to zero is passed through.
module adc_code_deskew
    import adc_corr_pkg::*;
#(
    parameter int N_RES         = 8,
    parameter int LANES_PER_CLK = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*N_RES-1:0]   raw_codes,
    output logic [2*N_RES-1:0]   aligned_codes
);

    localparam int SKEW_MAX = N_RES / LANES_PER_CLK;

    for (genvar k = 0; k < N_RES; k++) begin : g_lane
        localparam int LAG = lane_lag(k, LANES_PER_CLK, SKEW_MAX);

        if (LAG == 0) begin : g_pass
            assign aligned_codes[2*k +: 2] = raw_codes[2*k +: 2];
        end else begin : g_dly
            dcode_t taps [LAG];

            // Shift the lane's code one tap per clock; reset empties the line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < LAG; i++) taps[i] <= '0;
                end else begin
                    taps[0] <= raw_codes[2*k +: 2];
                    for (int i = 1; i < LAG; i++) taps[i] <= taps[i-1];
                end
            end

            assign aligned_codes[2*k +: 2] = taps[LAG-1];
        end
    end

endmodule

// File: rtl/adc_overlap_sum.sv
// Adds aligned stage codes at overlapping binary weights (front stage k,
// 0-based, weighs 2^(N_RES-k); flash weighs 1) and clamps to full scale.
// Purely combinational; assumes codes are already time-aligned.
module adc_overlap_sum
    import adc_corr_pkg::*;
#(
    parameter int N_RES = 8
) (
    input  logic [2*N_RES-1:0]  codes,
    input  logic [1:0]          flash,
    output logic [N_RES+1:0]    word,
    output logic                sat,
    output logic                legal
);

    localparam int OUT_W = N_RES + 2;
    localparam int SUM_W = OUT_W + 1;
    localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << OUT_W) - 1);

    logic [SUM_W-1:0] acc;

    // Weighted sum of all lanes and legality scan of the front codes.
    always_comb begin
        acc   = SUM_W'(flash);
        legal = 1'b1;
        for (int k = 0; k < N_RES; k++) begin
            acc = acc + (SUM_W'(codes[2*k +: 2]) << (N_RES - k));
            if (codes[2*k +: 2] == CODE_ILLEGAL) legal = 1'b0;
        end
    end

    // Pin to the top code when the sum leaves the output range.
    always_comb begin
        sat  = (acc > MAXV);
        word = sat ? MAXV[OUT_W-1:0] : acc[OUT_W-1:0];
    end

endmodule

// File: rtl/adc_fill_track.sv
// Raises a sticky valid flag once FILL clocks have passed since reset,
// i.e. once every deskew lane holds post-reset data.
module adc_fill_track #(
    parameter int FILL = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic valid
);

    localparam int CW = $clog2(FILL + 1);
    localparam logic [CW-1:0] LAST = CW'(FILL - 1);

    logic [CW-1:0] cnt;

    // Count post-reset clocks up to LAST, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    // Set valid on the clock that completes the fill; keep it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= valid | (cnt == LAST);
    end

    AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt < LAST) |-> !valid) else $error("valid before fill"); // R6

endmodule

// File: rtl/adc_digital_correct.sv
// Top of the pipelined ADC correction block: deskews eight redundant
// front-stage lanes against the flash code, adds them at overlapping
// weights, clamps, and registers the word with a fill-qualified strobe.
// Assumes stage lanes arrive two per clock in stage order (see brief).
module adc_digital_correct #(
    parameter int N_RES         = 8,
    parameter int LANES_PER_CLK = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*N_RES-1:0]   stage_codes,
    input  logic [1:0]           flash_code,
    output logic [N_RES+1:0]     out_word,
    output logic                 out_valid
);

    localparam int OUT_W    = N_RES + 2;
    localparam int SKEW_MAX = N_RES / LANES_PER_CLK;
    localparam int FILL     = SKEW_MAX + 1;
    localparam logic [OUT_W-1:0] TOP = '1;

    logic [2*N_RES-1:0] aligned;
    logic [OUT_W-1:0]   sum_word;
    logic               sum_sat;
    logic               sum_legal;
    logic               rst_seen_q;

    adc_code_deskew #(
        .N_RES         (N_RES),
        .LANES_PER_CLK (LANES_PER_CLK)
    ) u_deskew (
        .clk           (clk),
        .rst_n         (rst_n),
        .raw_codes     (stage_codes),
        .aligned_codes (aligned)
    );

    adc_overlap_sum #(
        .N_RES (N_RES)
    ) u_sum (
        .codes (aligned),
        .flash (flash_code),
        .word  (sum_word),
        .sat   (sum_sat),
        .legal (sum_legal)
    );

    adc_fill_track #(
        .FILL (FILL)
    ) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (out_valid)
    );

    // Output latch: hold the corrected word for one sampling clock.
    always_ff @(posedge clk) begin
        if (!rst_n) out_word <= '0;
        else        out_word <= sum_word;
    end

    // Remember that the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
        if (rst_seen_q) begin
            AST_RESET_CLEARS: assert (out_word == '0 && !out_valid)
                else $error("reset left state behind"); // R7
        end
    end

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid) else $error("valid dropped"); // R6

    AST_LEGAL_NO_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        sum_legal |-> !sum_sat) else $error("legal codes saturated"); // R4

    AST_SAT_PINS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        sum_sat |=> (out_word == TOP)) else $error("clamp not applied"); // R5

endmodule

// File: tb/adc_digital_correct_bench.sv
module adc_digital_correct_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] stage_codes = '0;
    logic [1:0]  flash_code = '0;
    logic [9:0]  out_word;
    logic        out_valid;

    int tests = 0;
    int fails = 0;
    int smp [0:39][1:9];
    int drv [0:63][1:9];

    adc_digital_correct u_adc_digital_correct (
        .clk         (clk),
        .rst_n       (rst_n),
        .stage_codes (stage_codes),
        .flash_code  (flash_code),
        .out_word    (out_word),
        .out_valid   (out_valid)
    );

    always #5 clk = ~clk;

    function automatic int weight(int k);
        return (k == 9) ? 1 : (1 << (9 - k));
    endfunction

    function automatic int lag(int k);
        return (k == 9) ? 0 : 4 - (k - 1) / 2;
    endfunction

    function automatic int clamp(int v);
        return (v > 1023) ? 1023 : v;
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_samples();
        for (int s = 0; s < 40; s++)
            for (int k = 1; k <= 9; k++) smp[s][k] = 0;
    endtask

    // Hold reset with garbage codes on every lane, check the cleared outputs.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        stage_codes = '1;
        stage_codes[1:0] = 2'd2;
        flash_code = 2'd3;
        repeat (3) @(negedge clk);
        check("R7", out_word, 0, "word in reset");
        check("R7", out_valid, 0, "valid in reset");
    endtask

    // Stream n samples with the staggered schedule; filler feeds absent samples.
    task automatic run_samples(string tag, int n, int filler);
        do_reset();
        for (int t = 0; t <= n + 4; t++) begin
            if (t > 0) @(negedge clk);
            if (t >= 1) begin
                int e = t - 1;
                int raw = 0;
                for (int k = 1; k <= 9; k++)
                    if (e - lag(k) >= 0) raw += drv[e - lag(k)][k] * weight(k);
                check("R2", out_word, clamp(raw), "cycle word");
                check("R6", out_valid, (e >= 4) ? 1 : 0, "valid");
                if (e >= 4) begin
                    int s = e - 4;
                    int sv = 0;
                    for (int k = 1; k <= 9; k++) sv += smp[s][k] * weight(k);
                    check(tag, out_word, clamp(sv), $sformatf("sample %0d", s));
                end
            end
            rst_n = 1'b1;
            for (int k = 1; k <= 9; k++) begin
                int s = t - ((k == 9) ? 4 : (k - 1) / 2);
                drv[t][k] = (s >= 0 && s < n) ? smp[s][k] : filler;
            end
            for (int k = 1; k <= 8; k++) stage_codes[2*k-2 +: 2] = 2'(drv[t][k]);
            flash_code = 2'(drv[t][9]);
        end
    endtask

    task automatic test_fill_after_reset(); // R6, R7
        clear_samples();
        for (int s = 0; s < 3; s++) for (int k = 1; k <= 9; k++) smp[s][k] = 1;
        run_samples("R7", 3, 2);
    endtask

    task automatic test_midscale(); // R1
        clear_samples();
        for (int s = 0; s < 4; s++) for (int k = 1; k <= 9; k++) smp[s][k] = 1;
        run_samples("R1", 4, 0);
        check("R1", out_word, 511, "midscale literal");
    endtask

    task automatic test_extremes(); // R4
        clear_samples();
        for (int k = 1; k <= 9; k++) smp[1][k] = (k == 9) ? 3 : 2;
        for (int k = 1; k <= 8; k++) smp[2][k] = 2;
        smp[3][9] = 3;
        run_samples("R4", 4, 0);
        check("R4", out_word, 3, "flash only literal");
    endtask

    task automatic test_weight_walk(); // R1
        clear_samples();
        for (int s = 0; s < 9; s++) smp[s][s + 1] = 1;
        run_samples("R1", 9, 0);
    endtask

    task automatic test_overlap(); // R8
        clear_samples();
        for (int s = 0; s < 8; s++) for (int k = 1; k <= 9; k++) smp[s][k] = 1;
        for (int p = 0; p < 4; p++) begin
            smp[2*p][p + 1] = 1;     smp[2*p][p + 2] = 0;
            smp[2*p + 1][p + 1] = 0; smp[2*p + 1][p + 2] = 2;
        end
        run_samples("R8", 8, 1);
    endtask

    task automatic test_stream(); // R3
        int seed = 32'h1234_5678;
        clear_samples();
        for (int s = 0; s < 24; s++)
            for (int k = 1; k <= 9; k++) begin
                seed = seed * 1103515245 + 12345;
                smp[s][k] = ((seed >>> 16) & 32'h7fff) % ((k == 9) ? 4 : 3);
            end
        run_samples("R3", 24, 0);
    endtask

    task automatic test_illegal(); // R5
        clear_samples();
        for (int k = 1; k <= 9; k++) smp[0][k] = 3;
        smp[1][1] = 3;
        smp[2][1] = 3;
        for (int k = 2; k <= 8; k++) smp[2][k] = 2;
        smp[2][9] = 3;
        run_samples("R5", 3, 0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog R3: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        test_fill_after_reset();
        test_midscale();
        test_extremes();
        test_weight_walk();
        test_overlap();
        test_stream();
        test_illegal();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule